// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask

This block collects the interrupt sources of an SD/MMC host controller into one 32-bit status register, holds a 32-bit disable mask beside it, and drives a single active-low, level-type interrupt line towards the processor. Single-cycle event pulses from the command, data and error logic set sticky status bits. Software acknowledges a bit by writing it as 0. A bit written as 1 keeps its value, so a handler can clear exactly the sources it has serviced without a read-modify-write race.

Card insertion and removal are derived inside the block from the raw card-detect input. That input is first brought into the clock domain through a synchroniser chain. The write-protect switch is passed through a matching synchroniser and shown live in the status word. It is never latched.

A mask bit at 1 disables its source. The mask comes out of reset with most sources disabled. The line goes low only for the serviced set of sources: command response end, command timeout, data end, card insert, card remove, receive ready and transmit request.

Top module: `sd_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x00000000, the mask reads 0x837F031D and irq_n is high.
- R2: An event pulse sets its status bit on the next clock edge, and the bit stays set until it is cleared. The bit positions are: command response end bit 0, data end bit 2, error vector ev_err[i] at bit 16+i for i = 0..6 (bit 22 is command timeout), receive ready bit 24, transmit request bit 25, illegal access bit 31.
- R3: A status write (reg_wr=1, reg_wsel=0) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: Status bits outside the defined set 0x837F009D always read 0, whatever is written.
- R6: Status bit 7 shows the write-protect level two clock edges after that level changes. It is not latched, and status writes do not affect it.
- R7: A rising edge of the synchronised card-detect level sets bit 4 (card inserted), and a falling edge sets bit 3 (card removed). Either bit becomes visible on the third clock edge after the raw input changes. A steady level produces no further events.
- R8: A mask write (reg_wr=1, reg_wsel=1) loads all 32 bits, and the new value reads back from the next cycle on.
- R9: irq_n is low in a cycle exactly when, one cycle earlier, (status AND NOT mask AND 0x0340001D) was non-zero.
- R10: Status bits 16 to 21, bit 31 and bit 7 never pull irq_n low, even when they are unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cmd_end | input | 1 | Command response end pulse |
| ev_data_end | input | 1 | Data transfer end pulse |
| ev_rx_ready | input | 1 | Receive buffer ready pulse |
| ev_tx_req | input | 1 | Transmit buffer request pulse |
| ev_err | input | 7 | Error pulses, bit i sets status bit 16+i |
| ev_ill_access | input | 1 | Illegal access pulse |
| card_det | input | 1 | Raw card-detect level (asynchronous) |
| wp_level | input | 1 | Raw write-protect switch level (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 status, 1 mask |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read source: 0 status, 1 mask |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_n | output | 1 | Registered active-low interrupt line |

## Verification
The hardest state to reach from the ports is the collision between a clearing status write and an event on the same bit in the same cycle. A close second is a card-detect edge that lands while other sources are being acknowledged. The random phase fires sparse event pulses while it issues status writes that are mostly ones with a few zeros. It also toggles card-detect and write-protect at random, so collisions and synchroniser-delayed edges occur many times. Directed steps force the exact collision and the unmasked non-serviced error sources.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

   localparam int STAT_W      = 32;
   localparam int ERR_N       = 7;

   localparam int B_CMD_END   = 0;
   localparam int B_DATA_END  = 2;
   localparam int B_CARD_OUT  = 3;
   localparam int B_CARD_IN   = 4;
   localparam int B_WPROT     = 7;
   localparam int B_ERR_LO    = 16;
   localparam int B_RX_READY  = 24;
   localparam int B_TX_REQ    = 25;
   localparam int B_ILL_ACC   = 31;

   localparam logic [STAT_W-1:0] DEFINED_BITS = 32'h837F_009D;
   localparam logic [STAT_W-1:0] SERVICED     = 32'h0340_001D;
   localparam logic [STAT_W-1:0] MASK_RST_DEF = 32'h837F_031D;

   typedef struct packed {
      logic             ill_acc;
      logic             tx_req;
      logic             rx_ready;
      logic [ERR_N-1:0] err;
      logic             card_in;
      logic             card_out;
      logic             data_end;
      logic             cmd_end;
   } evt_t;

   function automatic logic [STAT_W-1:0] evt_to_vec(input evt_t e);
      logic [STAT_W-1:0] v;
      v = '0;
      v[B_CMD_END]  = e.cmd_end;
      v[B_DATA_END] = e.data_end;
      v[B_CARD_OUT] = e.card_out;
      v[B_CARD_IN]  = e.card_in;
      for (int i = 0; i < ERR_N; i++) v[B_ERR_LO+i] = e.err[i];
      v[B_RX_READY] = e.rx_ready;
      v[B_TX_REQ]   = e.tx_req;
      v[B_ILL_ACC]  = e.ill_acc;
      return v;
   endfunction

endpackage

// File: rtl/sd_irq_sync.sv
module sd_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sd_irq_edge.sv
module sd_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status #(
   parameter int                W        = 32,
   parameter logic [W-1:0]      DEF_BITS = '1,
   parameter int                LIVE_BIT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         live_level,
   output logic [W-1:0] rd_vec
);
   localparam logic [W-1:0] LIVE_ONE   = {{(W-1){1'b0}}, 1'b1} << LIVE_BIT;
   localparam logic [W-1:0] STICKY_SET = DEF_BITS & ~LIVE_ONE;

   logic [W-1:0] stat_q;
   logic [W-1:0] keep;
   logic [W-1:0] stat_d;

   always_comb begin
      keep   = wr_en ? wr_data : '1;
      stat_d = ((stat_q & keep) | set_vec) & STICKY_SET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   always_comb begin
      rd_vec           = stat_q;
      rd_vec[LIVE_BIT] = live_level;
   end
endmodule

// File: rtl/sd_irq_out.sv
module sd_irq_out #(
   parameter int           W          = 32,
   parameter logic [W-1:0] SERV       = '1,
   parameter bit           ACTIVE_LOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat,
   input  logic [W-1:0] mask,
   output logic         irq_line
);
   logic pending;
   assign pending = |(stat & ~mask & SERV);

   if (ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_line <= 1'b1;
         else        irq_line <= ~pending;
      end
   end else begin : g_high
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_line <= 1'b0;
         else        irq_line <= pending;
      end
   end
endmodule

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl
   import sd_irq_pkg::*;
#(
   parameter int                 SYNC_STAGES = 2,
   parameter logic [STAT_W-1:0]  MASK_RESET  = MASK_RST_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_cmd_end,
   input  logic              ev_data_end,
   input  logic              ev_rx_ready,
   input  logic              ev_tx_req,
   input  logic [ERR_N-1:0]  ev_err,
   input  logic              ev_ill_access,
   input  logic              card_det,
   input  logic              wp_level,
   input  logic              reg_wr,
   input  logic              reg_wsel,
   input  logic [STAT_W-1:0] reg_wdata,
   input  logic              reg_rsel,
   output logic [STAT_W-1:0] reg_rdata,
   output logic              irq_n
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sd_irq_ctrl: SYNC_STAGES must be at least 2");
   end
   if (B_ERR_LO + ERR_N > B_RX_READY) begin : g_bad_err
      $error("sd_irq_ctrl: error field overlaps data bits");
   end

   logic              cd_sync, wp_sync;
   logic              cd_rise, cd_fall;
   evt_t              evt;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] stat_rd;
   logic [STAT_W-1:0] mask_q;

   sd_irq_sync #(.STAGES(SYNC_STAGES)) u_cd_sync (
      .clk(clk), .rst_n(rst_n), .async_in(card_det), .sync_out(cd_sync));

   sd_irq_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
      .clk(clk), .rst_n(rst_n), .async_in(wp_level), .sync_out(wp_sync));

   sd_irq_edge u_cd_edge (
      .clk(clk), .rst_n(rst_n), .level(cd_sync), .rise(cd_rise), .fall(cd_fall));

   always_comb begin
      evt.cmd_end  = ev_cmd_end;
      evt.data_end = ev_data_end;
      evt.card_out = cd_fall;
      evt.card_in  = cd_rise;
      evt.err      = ev_err;
      evt.rx_ready = ev_rx_ready;
      evt.tx_req   = ev_tx_req;
      evt.ill_acc  = ev_ill_access;
      set_vec      = evt_to_vec(evt);
   end

   sd_irq_status #(.W(STAT_W), .DEF_BITS(DEFINED_BITS), .LIVE_BIT(B_WPROT)) u_status (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .wr_en(reg_wr & ~reg_wsel), .wr_data(reg_wdata),
      .live_level(wp_sync), .rd_vec(stat_rd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mask_q <= MASK_RESET;
      else if (reg_wr && reg_wsel) mask_q <= reg_wdata;
   end

   sd_irq_out #(.W(STAT_W), .SERV(SERVICED), .ACTIVE_LOW(1'b1)) u_out (
      .clk(clk), .rst_n(rst_n), .stat(stat_rd), .mask(mask_q), .irq_line(irq_n));

   assign reg_rdata = reg_rsel ? mask_q : stat_rd;
endmodule

// File: rtl/sd_irq_ctrl_chk.sv
module sd_irq_ctrl_chk
   import sd_irq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ev_cmd_end,
   input logic              ev_data_end,
   input logic              reg_wr,
   input logic              reg_wsel,
   input logic [STAT_W-1:0] reg_wdata,
   input logic [STAT_W-1:0] stat_rd,
   input logic [STAT_W-1:0] mask_q,
   input logic              irq_n
);
   a_r2_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd_end |=> stat_rd[B_CMD_END]);

   a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[B_CMD_END] && !(reg_wr && !reg_wsel && !reg_wdata[B_CMD_END]))
      |=> stat_rd[B_CMD_END]);

   a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_data_end && reg_wr && !reg_wsel && !reg_wdata[B_DATA_END])
      |=> stat_rd[B_DATA_END]);

   a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd & ~DEFINED_BITS) == '0);

   a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wsel) |=> (mask_q == $past(reg_wdata)));

   a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_rd & ~mask_q & SERVICED) == '0) |=> irq_n);

   a_r9_irq_fires: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_rd & ~mask_q & SERVICED) != '0) |=> !irq_n);
endmodule

bind sd_irq_ctrl sd_irq_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ev_cmd_end(ev_cmd_end), .ev_data_end(ev_data_end),
   .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
   .stat_rd(stat_rd), .mask_q(mask_q), .irq_n(irq_n));

// File: tb/sd_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sd_irq_ctrl_tb;
   localparam logic [31:0] DEF  = 32'h837F_009D;
   localparam logic [31:0] SERV = 32'h0340_001D;
   localparam logic [31:0] MRST = 32'h837F_031D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_cmd_end = 0, ev_data_end = 0, ev_rx_ready = 0, ev_tx_req = 0;
   logic [6:0]  ev_err = '0;
   logic        ev_ill_access = 0, card_det = 0, wp_level = 0;
   logic        reg_wr = 0, reg_wsel = 0, reg_rsel = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_n;

   int checks = 0, failures = 0;

   logic [31:0] m_stat, m_mask;
   logic        m_irq_n;
   logic [1:0]  m_cd, m_wp;
   logic        m_cdp;

   always #2.5 clk = ~clk;

   sd_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ev_cmd_end(ev_cmd_end), .ev_data_end(ev_data_end),
      .ev_rx_ready(ev_rx_ready), .ev_tx_req(ev_tx_req), .ev_err(ev_err),
      .ev_ill_access(ev_ill_access), .card_det(card_det), .wp_level(wp_level),
      .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
      .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .irq_n(irq_n));

   function automatic logic [31:0] ev_vec(input logic ins, input logic rem);
      logic [31:0] v = '0;
      v[0] = ev_cmd_end; v[2] = ev_data_end; v[3] = rem; v[4] = ins;
      v[22:16] = ev_err; v[24] = ev_rx_ready; v[25] = ev_tx_req; v[31] = ev_ill_access;
      return v;
   endfunction

   function automatic string stat_req(input logic [31:0] diff);
      if (|(diff & ~DEF)) return "R5";
      if (diff[7])        return "R6";
      if (|diff[4:3])     return "R7";
      return "R3";
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read();
      logic [31:0] v = m_stat;
      v[7] = m_wp[1];
      return v;
   endfunction

   task automatic check_all(input string tag);
      logic [31:0] exp_s = m_read();
      reg_rsel = 1'b0; #0.5;
      chk(reg_rdata == exp_s, (tag == "") ? stat_req(reg_rdata ^ exp_s) : tag, reg_rdata, exp_s);
      reg_rsel = 1'b1; #0.5;
      chk(reg_rdata == m_mask, "R8", reg_rdata, m_mask);
      chk(irq_n == m_irq_n, "R9", {31'b0, irq_n}, {31'b0, m_irq_n});
      reg_rsel = 1'b0;
   endtask

   // inputs must be set before calling; advances one edge and updates the model
   task automatic step(input string tag);
      logic ins, rem;
      logic [31:0] keep;
      @(posedge clk);
      m_irq_n = ~|(m_read() & ~m_mask & SERV);
      ins = m_cd[1] & ~m_cdp;
      rem = ~m_cd[1] & m_cdp;
      m_cdp = m_cd[1];
      m_cd  = {m_cd[0], card_det};
      m_wp  = {m_wp[0], wp_level};
      keep  = (reg_wr && !reg_wsel) ? reg_wdata : 32'hFFFF_FFFF;
      m_stat = ((m_stat & keep) | ev_vec(ins, rem)) & DEF & ~32'h80;
      if (reg_wr && reg_wsel) m_mask = reg_wdata;
      #1;
      check_all(tag);
      @(negedge clk);
      ev_cmd_end = 0; ev_data_end = 0; ev_rx_ready = 0; ev_tx_req = 0;
      ev_err = '0; ev_ill_access = 0; reg_wr = 0; reg_wsel = 0;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_wr = 1; reg_wsel = sel; reg_wdata = d;
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5D1A_0C07));
      m_stat = '0; m_mask = MRST; m_irq_n = 1; m_cd = '0; m_wp = '0; m_cdp = 0;
      #12;
      // R1 reset state
      reg_rsel = 0; #0.5;
      chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
      reg_rsel = 1; #0.5;
      chk(reg_rdata == MRST, "R1", reg_rdata, MRST);
      chk(irq_n == 1'b1, "R1", {31'b0, irq_n}, 32'h1);
      reg_rsel = 0;
      @(negedge clk); rst_n = 1;
      step("R1");

      // R2 events set sticky bits; mask stays at reset so no irq
      ev_cmd_end = 1; ev_err = 7'h55; ev_ill_access = 1; step("R2");
      step("R2");
      // R8 unmask everything -> R9 irq
      wr(1, 32'h0); step("R8");
      step("R9");
      chk(irq_n == 1'b0, "R9", {31'b0, irq_n}, 32'h0);
      // R3 clear bit0 only
      wr(0, 32'hFFFF_FFFE); step("R3");
      // R4 collision on data end
      ev_data_end = 1; wr(0, 32'h0); step("R4");
      chk(reg_rdata[2] == 1'b1, "R4", reg_rdata, 32'h4);
      wr(0, 32'h0); step("R3");
      // R5 undefined bits
      wr(0, 32'hFFFF_FFFF); ev_err = 7'h7F; step("R5");
      chk((reg_rdata & ~DEF) == 0, "R5", reg_rdata, reg_rdata & DEF);
      // R10 non-serviced sources unmasked, no irq
      wr(0, 32'h0); step("R10");
      ev_err = 7'h3F; ev_ill_access = 1; wp_level = 1; step("R10");
      step("R10"); step("R10");
      chk(irq_n == 1'b1, "R10", {31'b0, irq_n}, 32'h1);
      // R6 write protect live, not cleared by writes
      wr(0, 32'h0); step("R6");
      chk(reg_rdata[7] == 1'b1, "R6", reg_rdata, 32'h80);
      wp_level = 0; step("R6");
      chk(reg_rdata[7] == 1'b1, "R6", reg_rdata, 32'h80);
      step("R6");
      chk(reg_rdata[7] == 1'b0, "R6", reg_rdata, 32'h0);
      ev_err[6] = 1; step("R9"); step("R9");
      chk(irq_n == 1'b0, "R9", {31'b0, irq_n}, 32'h0);
      wr(0, 32'h0); step("R9");
      // R7 card insert latency
      card_det = 1; step("R7"); step("R7");
      chk(reg_rdata[4] == 1'b0, "R7", reg_rdata, 32'h0);
      step("R7");
      chk(reg_rdata[4] == 1'b1, "R7", reg_rdata, 32'h10);
      wr(0, 32'h0); step("R7"); step("R7"); step("R7");
      chk(reg_rdata[4] == 1'b0, "R7", reg_rdata, 32'h0);
      card_det = 0; step("R7"); step("R7"); step("R7");
      chk(reg_rdata[3] == 1'b1, "R7", reg_rdata, 32'h8);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         ev_cmd_end    = ($urandom % 8) == 0;
         ev_data_end   = ($urandom % 8) == 0;
         ev_rx_ready   = ($urandom % 8) == 0;
         ev_tx_req     = ($urandom % 8) == 0;
         ev_ill_access = ($urandom % 16) == 0;
         ev_err        = (($urandom % 6) == 0) ? 7'($urandom) : 7'h0;
         if (($urandom % 10) == 0) card_det = ~card_det;
         if (($urandom % 12) == 0) wp_level = ~wp_level;
         case ($urandom % 8)
            0, 1: wr(0, $urandom | $urandom);
            2:    wr(0, $urandom);
            3:    wr(1, $urandom & $urandom);
            default: ;
         endcase
         step("");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule